// File: doc/BRIEF.md
# Buffered Synchronous Serial Port with Chip-Select Gating

This block is an 8-bit clock-synchronous serial channel that moves a block of bytes without the host handling each one. The host loads a 32-entry byte buffer, programs a byte count of 1 to 32, a bit order, a clock source and an optional chip-select mode, and then pulses a start input. The engine sends each buffer byte on the serial output. It captures the byte arriving on the serial input at the same time and writes it back over the location the outgoing byte came from. When the last byte is done it raises a completion flag and a one-cycle interrupt.

The serial clock either comes from an internal divider (master) or is taken from a pin, synchronised and edge-detected (slave). Data leaves on the falling serial-clock edge and is captured on the rising edge, with the clock idling high. In chip-select mode the data and clock drivers are enabled only while the select input is low. Raising the select input during a block stops the transfer and flags an error.

Top module: `sbx_xfer`

## Requirements
- R1: After reset, busy, done, err and irq are 0 and sck_out is 1. The configuration is all zeros: MSB-first, slave, no chip-select mode. So so_oe is 1 and sck_oe is 0.
- R2: In master mode, SCK idles high. Each bit is a low phase of HALF (default 8) system clocks followed by a high phase of HALF clocks, giving a 16-cycle period.
- R3: With cfg_wdata bit 0 = 0 (MSB-first), bit 7 of each byte goes out first and the first received bit lands in bit 7.
- R4: With cfg_wdata bit 0 = 1 (LSB-first), bit 0 of each byte goes out first and the first received bit lands in bit 0.
- R5: SO changes only on a falling SCK edge. The first bit of a block is on SO from the start pulse onward. SI is sampled on the rising edge.
- R6: Byte k of a block is sent from buffer entry k. The byte received at the same time overwrites entry k.
- R7: The count field cfg_wdata[7:3] holds N-1. A block moves exactly N bytes (1 to 32), and entries at N and above are left unchanged.
- R8: After the eighth rising edge of the last byte, busy falls, done goes to 1 and stays set until the next start, and irq is high for exactly one cycle.
- R9: While busy, configuration writes, host buffer writes and further start pulses have no effect.
- R10: With cfg_wdata bit 1 = 0 (slave), SCK comes from sck_in through a two-flop synchroniser. Data moves on its detected edges.
- R11: With cfg_wdata bit 2 = 1 (chip-select mode), so_oe and sck_oe are 0 while cs_n is 1. While cs_n is 0, so_oe is 1 and sck_oe equals the master bit. Without chip-select mode, so_oe is always 1.
- R12: In chip-select mode, a rising cs_n during a block aborts it. busy falls, err is set, done stays 0, no irq is raised, and the next block starts again from entry 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Config: [0] LSB-first, [1] master, [2] chip-select mode, [7:3] count-1 |
| cfg_q | output | 8 | Current configuration |
| start | input | 1 | Start pulse for a block |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | 5 | Host buffer address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Buffer entry at buf_addr |
| busy | output | 1 | Block transfer in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky abort flag |
| irq | output | 1 | One-cycle completion pulse |
| cs_n | input | 1 | Chip-select input, active low |
| sck_in | input | 1 | External serial clock (slave) |
| sck_out | output | 1 | Generated serial clock (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Serial data driver enable |

## Verification
The embedded properties check several rules on every cycle:
- SO moves only after a falling edge, a start or a change of bit order.
- The generated clock changes only on divider events.
- Rising and falling events never coincide.
- The interrupt is a single-cycle pulse.
- The configuration is frozen while busy.
- The buffer pointer is parked when idle.
- An abort never coexists with completion.

The bench scenarios show what a single cycle cannot: the 8/8 clock phases, the bit order of whole bytes, in-place write-back over exactly N entries, the slave path through the synchroniser, the driver gating by chip-select, and a clean restart after an abort.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  // configuration field positions
  localparam int CFG_LSB = 0;
  localparam int CFG_MST = 1;
  localparam int CFG_CSM = 2;
  localparam int CFG_CNT = 3;

  // bit presented on the line for the current shift state
  function automatic logic line_bit(input logic [7:0] b, input logic lsb);
    return lsb ? b[0] : b[7];
  endfunction

  // transmit register after one bit has left
  function automatic logic [7:0] tx_adv(input logic [7:0] b, input logic lsb);
    return lsb ? {1'b0, b[7:1]} : {b[6:0], 1'b0};
  endfunction

  // receive register after one bit has arrived
  function automatic logic [7:0] rx_adv(input logic [7:0] b, input logic s, input logic lsb);
    return lsb ? {s, b[7:1]} : {b[6:0], s};
  endfunction
endpackage

// File: rtl/sbx_edges.sv
module sbx_edges #(
  parameter int HALF = 8,
  localparam int PH_W = $clog2(2 * HALF)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic run,
  input  logic restart,
  input  logic sck_pin,
  output logic sck_drv,
  output logic fall_evt,
  output logic rise_evt
);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF - 1);

  logic [PH_W-1:0] ph;
  logic [1:0]      sync;
  logic            sync_q;

  wire m_fall = run & master & (ph == '0);
  wire m_rise = run & master & (ph == PH_HALF);
  wire s_fall = run & ~master & sync_q & ~sync[1];
  wire s_rise = run & ~master & ~sync_q & sync[1];

  assign fall_evt = m_fall | s_fall;
  assign rise_evt = m_rise | s_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      sck_drv <= 1'b1;
      sync    <= 2'b11;
      sync_q  <= 1'b1;
    end else begin
      sync   <= {sync[0], sck_pin};
      sync_q <= sync[1];
      if (restart) begin
        ph      <= '0;
        sck_drv <= 1'b1;
      end else if (run && master) begin
        ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        if (m_fall) sck_drv <= 1'b0;
        if (m_rise) sck_drv <= 1'b1;
      end
    end
  end

  AST_SCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_drv != $past(sck_drv)) |-> ($past(m_fall) || $past(m_rise) || $past(restart))); // R2
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_evt && rise_evt)); // R10
endmodule

// File: rtl/sbx_buf.sv
module sbx_buf #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wd,
  output logic [7:0]    host_rd,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_wd,
  output logic [7:0]    eng_rd
);
  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (eng_we && eng_addr == AW'(i))
        mem[i] <= eng_wd;
      else if (host_we && host_addr == AW'(i))
        mem[i] <= host_wd;
    end
  end

  assign host_rd = mem[host_addr];
  assign eng_rd  = mem[eng_addr];
endmodule

// File: rtl/sbx_shift.sv
module sbx_shift import sbx_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       clr,
  input  logic       fall,
  input  logic       rise,
  input  logic       si,
  input  logic       lsb,
  input  logic [7:0] next_byte,
  output logic       so,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [7:0] tx, rx;
  logic [2:0] bit_cnt;
  logic       pend;

  assign rx_byte   = rx_adv(rx, si, lsb);
  assign byte_done = rise & (bit_cnt == 3'd7);
  assign so        = line_bit(tx, lsb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0; rx <= '0; bit_cnt <= '0; pend <= 1'b0;
    end else if (load) begin
      tx <= next_byte; rx <= '0; bit_cnt <= '0; pend <= 1'b0;
    end else if (clr) begin
      bit_cnt <= '0; pend <= 1'b0;
    end else begin
      if (fall) begin
        if (pend) begin
          tx   <= next_byte;
          pend <= 1'b0;
        end else if (bit_cnt != 3'd0) begin
          tx <= tx_adv(tx, lsb);
        end
      end
      if (rise) begin
        rx      <= rx_byte;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) pend <= 1'b1;
      end
    end
  end

  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall) && !$past(load) && $stable(lsb)) |-> $stable(so)); // R5
endmodule

// File: rtl/sbx_xfer.sv
module sbx_xfer import sbx_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int HALF  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CFG_W = CFG_CNT + AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  input  logic             start,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_wdata,
  output logic [7:0]       buf_rdata,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             irq,
  input  logic             cs_n,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             si,
  output logic             so,
  output logic             so_oe
);
  logic [CFG_W-1:0] cfg_r;
  logic             active, done_r, err_r, irq_r;
  logic [AW-1:0]    ptr, remain;
  logic [2:0]       cs_s;

  wire          cfg_lsb = cfg_r[CFG_LSB];
  wire          cfg_mst = cfg_r[CFG_MST];
  wire          cfg_csm = cfg_r[CFG_CSM];
  wire [AW-1:0] cfg_cnt = cfg_r[CFG_CNT +: AW];

  // named internal events
  wire start_ok  = start & ~active;
  wire cs_hi     = cs_s[1];
  wire cs_rise   = cs_s[1] & ~cs_s[2];
  wire abort_evt = active & cfg_csm & cs_rise;
  wire run       = active & (~cfg_csm | ~cs_hi);
  logic       ev_fall, ev_rise, byte_done;
  logic [7:0] rx_byte, eng_rd;

  sbx_edges #(.HALF(HALF)) u_edges (
    .clk(clk), .rst_n(rst_n), .master(cfg_mst), .run(run), .restart(start_ok),
    .sck_pin(sck_in), .sck_drv(sck_out), .fall_evt(ev_fall), .rise_evt(ev_rise)
  );

  sbx_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .host_we(buf_we & ~active), .host_addr(buf_addr), .host_wd(buf_wdata), .host_rd(buf_rdata),
    .eng_we(byte_done), .eng_addr(ptr), .eng_wd(rx_byte), .eng_rd(eng_rd)
  );

  sbx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .clr(abort_evt),
    .fall(ev_fall), .rise(ev_rise), .si(si), .lsb(cfg_lsb),
    .next_byte(eng_rd), .so(so), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r <= '0; active <= 1'b0; done_r <= 1'b0; err_r <= 1'b0; irq_r <= 1'b0;
      ptr <= '0; remain <= '0; cs_s <= 3'b111;
    end else begin
      irq_r <= 1'b0;
      cs_s  <= {cs_s[1:0], cs_n};
      if (cfg_we && !active) cfg_r <= cfg_wdata;
      if (start_ok) begin
        active <= 1'b1; ptr <= '0; remain <= cfg_cnt; done_r <= 1'b0; err_r <= 1'b0;
      end else if (abort_evt) begin
        active <= 1'b0; ptr <= '0; err_r <= 1'b1;
      end else if (byte_done) begin
        if (remain == '0) begin
          active <= 1'b0; ptr <= '0; done_r <= 1'b1; irq_r <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
          ptr    <= ptr + 1'b1;
        end
      end
    end
  end

  assign cfg_q  = cfg_r;
  assign busy   = active;
  assign done   = done_r;
  assign err    = err_r;
  assign irq    = irq_r;
  assign so_oe  = ~cfg_csm | ~cs_n;
  assign sck_oe = cfg_mst & so_oe;

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_r |=> !irq_r); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> !active); // R8
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_r) |-> (!active && !done_r)); // R12
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(cfg_r)); // R9
  AST_PTR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (ptr == '0)); // R6
endmodule

// File: tb/sim_sbx_xfer.sv
module sim_sbx_xfer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, start = 1'b0, buf_we = 1'b0;
  logic [7:0] cfg_wdata = '0, buf_wdata = '0;
  logic [4:0] buf_addr = '0;
  logic cs_n = 1'b1, sck_in = 1'b1, si = 1'b0;
  logic [7:0] cfg_q, buf_rdata;
  logic busy, done, err, irq, sck_out, sck_oe, so, so_oe;

  int tests = 0, fails = 0, irq_cnt = 0, cycles = 0;
  logic [7:0] model [32];
  logic [7:0] rxd [32];

  always #5 clk = ~clk;

  sbx_xfer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .start(start), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .busy(busy), .done(done), .err(err), .irq(irq),
    .cs_n(cs_n), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .si(si), .so(so), .so_oe(so_oe)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg_word(input bit lsb, input bit mst, input bit csm, input int n);
    return {5'(n - 1), csm, mst, lsb};
  endfunction

  // position in the byte of the i-th bit on the line
  function automatic int bitpos(input bit lsb, input int i);
    return lsb ? i : 7 - i;
  endfunction

  task automatic wr_cfg(input logic [7:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic fill_buf();
    for (int a = 0; a < 32; a++) begin
      model[a] = 8'($urandom);
      @(negedge clk); buf_we = 1'b1; buf_addr = 5'(a); buf_wdata = model[a];
    end
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic rd_buf(input int a, output logic [7:0] d);
    buf_addr = 5'(a); #1; d = buf_rdata;
  endtask

  task automatic run_xfer(input bit mst, input bit lsb, input bit csm, input int n, input bit poke);
    logic [7:0] got, d, w;
    logic sob;
    int irq0, lw, hw, glitch, mism;
    string ord;
    ord = lsb ? "R4" : "R3";
    fill_buf();
    w = cfg_word(lsb, mst, csm, n);
    wr_cfg(w);
    for (int b = 0; b < n; b++) rxd[b] = 8'($urandom);
    irq0 = irq_cnt; glitch = 0; sob = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      // R9: writes and a second start while busy must be dropped
      cfg_we = 1'b1; cfg_wdata = ~w; buf_we = 1'b1; buf_addr = 5'd31;
      buf_wdata = ~model[31]; start = 1'b1;
      @(negedge clk); cfg_we = 1'b0; buf_we = 1'b0; start = 1'b0;
      chk(cfg_q == w, "R9 cfg held", int'(cfg_q), int'(w));
    end
    for (int b = 0; b < n; b++) begin
      got = '0;
      for (int i = 0; i < 8; i++) begin
        if (mst) begin
          hw = 0;
          while (sck_out) begin
            if ((b != 0 || i != 0) && so != sob) glitch++;
            @(negedge clk); hw++;
          end
          if (b == 0 && i == 1) chk(hw == 8, "R2 high phase", hw, 8);
          sob = so;
          si = rxd[b][bitpos(lsb, i)];
          lw = 0;
          while (!sck_out) begin
            if (so != sob) glitch++;
            @(negedge clk); lw++;
          end
          if (b == 0 && i == 0) chk(lw == 8, "R2 low phase", lw, 8);
        end else begin
          sck_in = 1'b0;
          repeat (6) @(negedge clk);
          sob = so;
          si = rxd[b][bitpos(lsb, i)];
          sck_in = 1'b1;
          repeat (6) @(negedge clk);
        end
        got[bitpos(lsb, i)] = sob;
      end
      chk(got == model[b], ord, int'(got), int'(model[b]));
    end
    if (mst) chk(glitch == 0, "R5 SO stable between falls", glitch, 0);
    repeat (4) @(negedge clk);
    chk(done && !busy && !err, "R8 done", int'({done, busy, err}), 4);
    chk(irq_cnt - irq0 == 1, "R8 irq pulses", irq_cnt - irq0, 1);
    mism = 0;
    for (int a = 0; a < 32; a++) begin
      rd_buf(a, d);
      if (d !== ((a < n) ? rxd[a] : model[a])) mism++;
    end
    chk(mism == 0, (n == 32 || n == 1) ? "R7 count edge" : "R6 write-back", mism, 0);
  endtask

  initial begin
    logic [7:0] d;
    int irq0, falls;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !done && !err && !irq, "R1 flags", int'({busy, done, err, irq}), 0);
    chk(sck_out && so_oe && !sck_oe && cfg_q == 8'h00, "R1 lines", int'({sck_out, so_oe, sck_oe}), 6);

    run_xfer(1'b1, 1'b0, 1'b0, 3, 1'b0);   // master MSB-first
    run_xfer(1'b1, 1'b1, 1'b0, 1, 1'b0);   // R7 minimum count, LSB-first
    run_xfer(1'b1, 1'b0, 1'b0, 32, 1'b0);  // R7 full buffer
    run_xfer(1'b0, 1'b1, 1'b0, 4, 1'b1);   // R10 slave, with R9 pokes
    run_xfer(1'b0, 1'b0, 1'b0, 2, 1'b0);   // R10 slave MSB-first

    for (int k = 0; k < 12; k++)
      run_xfer(1'($urandom), 1'($urandom), 1'b0, 1 + int'($urandom % 6), 1'b0);

    // R11 driver gating
    wr_cfg(cfg_word(1'b0, 1'b1, 1'b1, 2));
    cs_n = 1'b1; @(negedge clk);
    chk(!so_oe && !sck_oe, "R11 floated", int'({so_oe, sck_oe}), 0);
    cs_n = 1'b0; repeat (3) @(negedge clk);
    chk(so_oe && sck_oe, "R11 driven", int'({so_oe, sck_oe}), 3);
    wr_cfg(cfg_word(1'b0, 1'b0, 1'b0, 2));
    cs_n = 1'b1; @(negedge clk);
    chk(so_oe && !sck_oe, "R11 no cs mode", int'({so_oe, sck_oe}), 2);
    cs_n = 1'b0; repeat (3) @(negedge clk);
    run_xfer(1'b1, 1'b0, 1'b1, 2, 1'b0);

    // R12 abort mid-block
    fill_buf();
    wr_cfg(cfg_word(1'b0, 1'b1, 1'b1, 4));
    irq0 = irq_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    falls = 0;
    while (falls < 2) begin
      while (sck_out) @(negedge clk);
      falls++;
      while (!sck_out) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(err && !busy && !done, "R12 abort flags", int'({err, busy, done}), 4);
    chk(irq_cnt == irq0, "R12 no irq", irq_cnt - irq0, 0);
    rd_buf(0, d);
    chk(d == model[0], "R12 entry kept", int'(d), int'(model[0]));
    cs_n = 1'b0; repeat (3) @(negedge clk);
    run_xfer(1'b1, 1'b1, 1'b1, 3, 1'b0);
    chk(!err, "R12 err cleared by restart", int'(err), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule